// File: doc/BRIEF.md
# Interrupt and Subroutine Stack Sequencer

This block carries out the control transfers of a small 8-bit processor core: the software interrupt, the subroutine call and return, the interrupt return, and entry into the maskable and non-maskable hardware interrupts. It owns the program counter, the 8-bit stack pointer and the status byte. It talks to a single-port byte memory that answers reads in the same cycle. It makes exactly one access per clock. It raises a one-cycle completion pulse when the new program counter is in place.

The surrounding core offers an opcode with a `start` strobe, and supplies the call target on `jsr_target` in that same cycle. Interrupt lines are watched whenever the sequencer is idle. A pending non-maskable request wins over everything. An unmasked maskable request comes next, and a new opcode comes last. The cycle in which `done` is high already counts as idle.

Top module: `stack_xfer_seq`

## Requirements
- R1: The sequencer asserts `mem_en` only while `busy` is high, and then on every cycle, with one access per cycle. The first access comes in the cycle after the request is taken.
- R2: Stack accesses use address 0x0100 plus SP. A push writes at SP and then decrements it. A pull first increments SP and then reads at the new value. SP wraps modulo 256, so 0xFF+1 reads 0x0100 and 0x00-1 leaves 0xFF.
- R3: Opcode 0x00 pushes PC[15:8], then PC[7:0], then the status byte. It then reads the new PC low byte from 0xFFFE and the high byte from 0xFFFF, and sets status bit 4 after the push.
- R4: Opcode 0x20 pushes the high byte and then the low byte of PC-1, with the borrow carried into the high byte. It then loads PC with the `jsr_target` value sampled when the request was taken.
- R5: Opcode 0x60 pulls the low byte and then the high byte, and loads PC with that value plus one.
- R6: Opcode 0x40 pulls the whole status byte, then the PC low byte, then the PC high byte, and applies no adjustment.
- R7: A high `irq` is taken only while status bit 2 is clear. It pushes like R3, uses the 0xFFFE/0xFFFF vector and sets bit 2 once the push is done. While bit 2 is set, `irq` causes no access and no state change.
- R8: A rising edge of `nmi` is taken regardless of bit 2, and before `irq`. It pushes like R3 and fetches from 0xFFFA (low) and 0xFFFB (high). It leaves status unchanged. A level held high does not retrigger.
- R9: `done` is high for exactly one cycle, the cycle after the final access. The new PC, SP and status are visible in that cycle.
- R10: `start` with an opcode other than 0x00, 0x20, 0x40 or 0x60 causes no access and no state change.
- R11: After reset PC is 0x0200, SP is 0xFF, status is 0x00, and `busy`, `done`, `mem_en` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a transfer for `opcode` (considered only when idle) |
| opcode | input | 8 | Opcode of the requested transfer |
| jsr_target | input | 16 | Call destination, sampled with `start` |
| irq | input | 1 | Level-sensitive maskable interrupt request |
| nmi | input | 1 | Edge-sensitive non-maskable interrupt request |
| mem_en | output | 1 | A memory access is made this cycle |
| mem_we | output | 1 | The access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for `mem_addr` in the same cycle |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Status byte (bit 2 interrupt disable, bit 4 break) |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker watches some rules on every cycle. Memory is quiet while idle. Every write stays in page one and moves SP down by one. The completion pulse never lasts two cycles. A masked maskable request never starts a transfer. Only the bench's scenarios can show the rest: the order and content of the pushed and pulled bytes, the vector addresses, the minus-one and plus-one return rules, NMI priority and edge behaviour, stack pointer wrap at both ends, and rejection of other opcodes. The bench compares each of these cycle by cycle against its own model of memory and registers.

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq #(
  parameter logic [15:0] RESET_PC     = 16'h0200,
  parameter logic [7:0]  RESET_SP     = 8'hFF,
  parameter logic [7:0]  RESET_STATUS = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [15:0] jsr_target,
  input  logic        irq,
  input  logic        nmi,
  output logic        mem_en,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pc,
  output logic [7:0]  sp,
  output logic [7:0]  status,
  output logic        busy,
  output logic        done
);
  localparam logic [7:0]  STACK_PAGE = 8'h01;
  localparam logic [15:0] VEC_MASK   = 16'hFFFE;
  localparam logic [15:0] VEC_NMI    = 16'hFFFA;
  localparam int          BIT_I      = 2;
  localparam int          BIT_B      = 4;

  typedef enum logic [2:0] {K_BRK, K_JSR, K_RTI, K_RTS, K_IRQ, K_NMI} kind_t;

  logic        active, done_q, nmi_q, nmi_pend, last;
  kind_t       kind;
  logic [2:0]  step;
  logic [7:0]  lo_q, sp_q, st_q;
  logic [15:0] pc_q, tgt_q;

  wire nmi_rise = nmi & ~nmi_q;
  wire nmi_req  = nmi_pend | nmi_rise;
  wire irq_ok   = irq & ~st_q[BIT_I];
  wire op_ok    = ~opcode[7] & (opcode[4:0] == 5'd0);
  wire take_nmi = ~active & nmi_req;
  wire take_irq = ~active & ~nmi_req & irq_ok;
  wire take_op  = ~active & ~nmi_req & ~irq_ok & start & op_ok;
  wire is_push  = (kind == K_BRK) | (kind == K_IRQ) | (kind == K_NMI);
  wire is_pull  = (kind == K_RTI) | (kind == K_RTS);
  wire [15:0] ret = pc_q - 16'd1;
  wire [15:0] vec = (kind == K_NMI) ? VEC_NMI : VEC_MASK;
  wire [7:0]  sp_up = sp_q + 8'd1;

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = {STACK_PAGE, sp_q};
    mem_wdata = 8'h00;
    last      = 1'b0;
    if (is_push) begin
      case (step)
        3'd0: begin mem_we = 1'b1; mem_wdata = pc_q[15:8]; end
        3'd1: begin mem_we = 1'b1; mem_wdata = pc_q[7:0]; end
        3'd2: begin mem_we = 1'b1; mem_wdata = st_q; end
        3'd3: mem_addr = vec;
        default: begin mem_addr = vec | 16'd1; last = 1'b1; end
      endcase
    end else if (kind == K_JSR) begin
      mem_we    = 1'b1;
      mem_wdata = (step == 3'd0) ? ret[15:8] : ret[7:0];
      last      = (step != 3'd0);
    end else begin
      mem_addr = {STACK_PAGE, sp_up};
      last     = (kind == K_RTS) ? (step == 3'd1) : (step == 3'd2);
    end
    mem_we = mem_we & active;
    last   = last & active;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      done_q   <= 1'b0;
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
      kind     <= K_BRK;
      step     <= 3'd0;
      lo_q     <= 8'h00;
      tgt_q    <= 16'h0000;
      pc_q     <= RESET_PC;
      sp_q     <= RESET_SP;
      st_q     <= RESET_STATUS;
    end else begin
      nmi_q    <= nmi;
      nmi_pend <= (nmi_pend | nmi_rise) & ~take_nmi;
      done_q   <= last;
      if (take_nmi || take_irq || take_op) begin
        active <= 1'b1;
        step   <= 3'd0;
        tgt_q  <= jsr_target;
        if (take_nmi)      kind <= K_NMI;
        else if (take_irq) kind <= K_IRQ;
        else               kind <= kind_t'({1'b0, opcode[6:5]});
      end
      if (active) begin
        step <= step + 3'd1;
        if (mem_we)  sp_q <= sp_q - 8'd1;
        if (is_pull) sp_q <= sp_up;
        if (last)    active <= 1'b0;
        case (kind)
          K_JSR: if (last) pc_q <= tgt_q;
          K_RTS: if (step == 3'd0) lo_q <= mem_rdata;
                 else pc_q <= {mem_rdata, lo_q} + 16'd1;
          K_RTI: if (step == 3'd0) st_q <= mem_rdata;
                 else if (step == 3'd1) lo_q <= mem_rdata;
                 else pc_q <= {mem_rdata, lo_q};
          default: begin
            if (step == 3'd3) lo_q <= mem_rdata;
            if (last) begin
              pc_q <= {mem_rdata, lo_q};
              if (kind == K_BRK) st_q[BIT_B] <= 1'b1;
              if (kind == K_IRQ) st_q[BIT_I] <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign mem_en = active;
  assign pc     = pc_q;
  assign sp     = sp_q;
  assign status = st_q;
  assign busy   = active;
  assign done   = done_q;
endmodule

// File: rtl/stack_xfer_seq_chk.sv
module stack_xfer_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_en,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  sp,
  input logic [7:0]  status,
  input logic        irq,
  input logic        start,
  input logic        nmi_req
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en); // R1
  AST_WRITE_IS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en); // R1
  AST_WRITE_IN_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == 8'h01); // R2
  AST_PUSH_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == $past(sp) - 8'd1); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && irq && status[2] && !nmi_req && !start) |=> !busy); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

bind stack_xfer_seq stack_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_en(mem_en),
  .mem_we(mem_we), .mem_addr(mem_addr), .sp(sp), .status(status),
  .irq(irq), .start(start), .nmi_req(nmi_req)
);

// File: tb/stack_xfer_seq_tb.sv
module stack_xfer_seq_tb;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, irq = 1'b0, nmi = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] jsr_target = 16'h0000;
  logic        mem_en, mem_we, busy, done;
  logic [15:0] mem_addr, pc;
  logic [7:0]  mem_wdata, mem_rdata, sp, status;

  always #2 clk = ~clk;

  stack_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .jsr_target(jsr_target),
    .irq(irq), .nmi(nmi), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .status(status),
    .busy(busy), .done(done)
  );

  logic [7:0] stk [256];
  function automatic logic [7:0] rd(input logic [15:0] a);
    if (a[15:8] == 8'h01) return stk[a[7:0]];
    case (a)
      16'hFFFE: return 8'h00;
      16'hFFFF: return 8'h80;
      16'hFFFA: return 8'h34;
      16'hFFFB: return 8'h90;
      default:  return 8'hEE;
    endcase
  endfunction
  assign mem_rdata = rd(mem_addr);
  always @(posedge clk) if (mem_en && mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

  int vectors = 0, miscompares = 0;
  logic [15:0] e_pc = 16'h0200;
  logic [7:0]  e_sp = 8'hFF, e_st = 8'h00;

  typedef struct packed { logic we; logic [15:0] a; logic [7:0] d; } acc_t;

  task automatic cmp(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic exp_done);
    cmp(req, "done", {15'd0, done}, {15'd0, exp_done});
    cmp(req, "busy", {15'd0, busy}, 16'd0);
    cmp(req, "mem_en", {15'd0, mem_en}, 16'd0);
    cmp(req, "pc", pc, e_pc);
    cmp(req, "sp", {8'd0, sp}, {8'd0, e_sp});
    cmp(req, "status", {8'd0, status}, {8'd0, e_st});
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_state(req, 1'b0);
    end
  endtask

  // kinds: 0 brk, 1 call, 2 int-return, 3 return, 4 irq, 5 nmi
  task automatic expect_seq(input int kind, input string req);
    acc_t q[$];
    logic [7:0]  s, lo, hi;
    logic [15:0] r, v;
    s = e_sp;
    if (kind == 0 || kind == 4 || kind == 5) begin
      v = (kind == 5) ? 16'hFFFA : 16'hFFFE;
      q.push_back({1'b1, 8'h01, s, e_pc[15:8]}); s = s - 8'd1;
      q.push_back({1'b1, 8'h01, s, e_pc[7:0]});  s = s - 8'd1;
      q.push_back({1'b1, 8'h01, s, e_st});       s = s - 8'd1;
      q.push_back({1'b0, v, 8'h00});
      q.push_back({1'b0, v + 16'd1, 8'h00});
      e_pc = {rd(v + 16'd1), rd(v)};
      if (kind == 0) e_st = e_st | 8'h10;
      if (kind == 4) e_st = e_st | 8'h04;
    end else if (kind == 1) begin
      r = e_pc - 16'd1;
      q.push_back({1'b1, 8'h01, s, r[15:8]}); s = s - 8'd1;
      q.push_back({1'b1, 8'h01, s, r[7:0]});  s = s - 8'd1;
      e_pc = jsr_target;
    end else begin
      if (kind == 2) begin
        s = s + 8'd1; q.push_back({1'b0, 8'h01, s, 8'h00}); e_st = stk[s];
      end
      s = s + 8'd1; q.push_back({1'b0, 8'h01, s, 8'h00}); lo = stk[s];
      s = s + 8'd1; q.push_back({1'b0, 8'h01, s, 8'h00}); hi = stk[s];
      e_pc = (kind == 3) ? {hi, lo} + 16'd1 : {hi, lo};
    end
    e_sp = s;
    foreach (q[i]) begin
      @(negedge clk);
      start = 1'b0;
      cmp(req, "mem_en", {15'd0, mem_en}, 16'd1);
      cmp(req, "busy", {15'd0, busy}, 16'd1);
      cmp(req, "done", {15'd0, done}, 16'd0);
      cmp(req, "mem_we", {15'd0, mem_we}, {15'd0, q[i].we});
      cmp(req, "mem_addr", mem_addr, q[i].a);
      if (q[i].we) cmp(req, "mem_wdata", {8'd0, mem_wdata}, {8'd0, q[i].d});
    end
    @(negedge clk);
    check_state("R9", 1'b1);
  endtask

  task automatic launch(input logic [7:0] op, input logic [15:0] tgt);
    start = 1'b1; opcode = op; jsr_target = tgt;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_state("R11", 1'b0);
    cmp("R11", "mem_we", {15'd0, mem_we}, 16'd0);
    launch(8'h20, 16'h1234); expect_seq(1, "R4");  // PC-1 borrow: 0x0200 -> 0x01FF
    launch(8'h60, 16'h0000); expect_seq(3, "R5");
    launch(8'h00, 16'h0000); expect_seq(0, "R3");
    launch(8'h40, 16'h0000); expect_seq(2, "R6");
    irq = 1'b1;              expect_seq(4, "R7");
    idle("R7", 4);           // I set: masked
    irq = 1'b0;
    nmi = 1'b1;              expect_seq(5, "R8");
    idle("R8", 3);           // held level, no retrigger
    nmi = 1'b0;
    launch(8'h40, 16'h0000); expect_seq(2, "R6");
    launch(8'h40, 16'h0000); expect_seq(2, "R6");
    launch(8'hEA, 16'h5555); @(negedge clk); start = 1'b0;
    check_state("R10", 1'b0);
    idle("R10", 2);
    nmi = 1'b1; irq = 1'b1;  expect_seq(5, "R8");  // NMI first
    expect_seq(4, "R8");     // IRQ follows from the done cycle
    irq = 1'b0; nmi = 1'b0;
    launch(8'h40, 16'h0000); expect_seq(2, "R6");
    launch(8'h40, 16'h0000); expect_seq(2, "R6");
    launch(8'h60, 16'h0000); expect_seq(3, "R2");  // pull wraps 0xFF -> 0x00
    launch(8'h20, 16'h0400); expect_seq(1, "R2");  // push wraps 0x00 -> 0xFF
    idle("R9", 2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule